// File: doc/BRIEF.md
# Modem Keying Source Selector

This block decides, for each of two voice-band modem ports, what drives the port's push-to-talk line and its two mode lines. Each port has two small write-only registers. The first is a select register that names the keying source. The second is a control register that is used only in the debug source. Software writes both registers over a simple write bus. The block then routes the chosen source to the port's outputs.

A port can be keyed by the request-to-send line of a serial controller channel, or by the request-to-send line of a software-driven bit-bang channel. It can also be keyed straight from its own control register for test work, or it can be switched off. Each port is tied to a fixed channel of each kind. Both request-to-send inputs are active low.

The three keying outputs are registered. Each one follows its source, or a register write, with one clock of delay. After reset both ports are off and show the idle pattern.

Top module: `modem_key_sel`

## Requirements
- R1: After reset, both select registers and both control registers read as zero. Every port shows the idle pattern: ptt=0, m0=0, m1=1. This holds whatever the request-to-send inputs do.
- R2: Select value 4'h1 keys port p from `uart_rts_n[p]` (bit 0 is serial channel A, bit 1 is channel B). A low input gives ptt=1, m0=1, m1=0. A high input gives ptt=0, m0=0, m1=1.
- R3: Select value 4'h2 keys port p from `bb_rts_n[p]` (bit 0 is bit-bang channel 0, bit 1 is channel 1). It uses the same low/high mapping as R2.
- R4: Select value 4'h4 is the debug source. Control register bit 0 drives ptt, bit 1 drives m0 and bit 2 drives m1. Bit 3 has no effect.
- R5: Select value 4'h0 and the reserved values 4'h3 and 4'h5 to 4'hF give the idle pattern (ptt=0, m0=0, m1=1). No request-to-send input and no control value changes it.
- R6: Writes are decoded on the full 32-bit address. Port 1 select is at 0xB402_0008 and port 1 control at 0xB402_0009. Port 2 select is at 0xB402_000A and port 2 control at 0xB402_000B. A write to any other address changes no register.
- R7: When `wr_en` is low, no register changes, whatever `wr_addr` and `wr_data` hold.
- R8: Each output changes at the first clock edge after the edge that captured a changed input or a register write. It never changes in the same cycle.
- R9: The two ports are independent. Each port's outputs depend only on its own registers and its own fixed pair of channel inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 32 | Byte address of the write |
| wr_data | input | 4 | Write data, the low nibble of the register |
| uart_rts_n | input | 2 | Serial channel request-to-send, active low, bit p for port p |
| bb_rts_n | input | 2 | Bit-bang channel request-to-send, active low, bit p for port p |
| ptt_o | output | 2 | Push-to-talk per port, active high |
| m0_o | output | 2 | Mode line 0 per port |
| m1_o | output | 2 | Mode line 1 per port |

## Verification
The assertions assume that the request-to-send inputs and the write bus are synchronous to `clk` and hold steady around each rising edge. Any synchronizing of the channel lines is done before this block. The assertions also assume that register contents change only through bus writes. The bench drives every input on the falling edge and samples on the falling edge. It sweeps all sixteen select values on each port, with the two ports held on different values. For each setting it steps through every control nibble and every combination of the four request-to-send lines.

// File: rtl/modem_key_pkg.sv
// Package: shared types and constants for the modem keying selector.
// Assumes: select and control registers are four bits wide per port.
package modem_key_pkg;

    localparam int REG_W = 4;

    // Select codes that pick a live source; every other code means "off".
    localparam logic [REG_W-1:0] SEL_OFF   = 4'h0;
    localparam logic [REG_W-1:0] SEL_UART  = 4'h1;
    localparam logic [REG_W-1:0] SEL_BBANG = 4'h2;
    localparam logic [REG_W-1:0] SEL_DEBUG = 4'h4;

    // Bit positions of the keying lines inside a control register.
    localparam int CTL_PTT_BIT = 0;
    localparam int CTL_M0_BIT  = 1;
    localparam int CTL_M1_BIT  = 2;

    typedef struct packed {
        logic ptt;
        logic m0;
        logic m1;
    } key_t;

    localparam key_t KEY_IDLE = '{ptt: 1'b0, m0: 1'b0, m1: 1'b1};
    localparam key_t KEY_TX   = '{ptt: 1'b1, m0: 1'b1, m1: 1'b0};

    // Map an active-low request-to-send level to the keying pattern.
    function automatic key_t key_from_rts(input logic rts_n);
        return rts_n ? KEY_IDLE : KEY_TX;
    endfunction

endpackage

// File: rtl/modem_key_regs.sv
// Module: write-only select and control registers, one pair per port.
// Assumes: full-address decode; port p's select register sits at
// BASE_ADDR + 2p and its control register at BASE_ADDR + 2p + 1.
module modem_key_regs
    import modem_key_pkg::*;
#(
    parameter int                NUM_PORTS = 2,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hB402_0008
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [REG_W-1:0]                    wr_data,
    output logic [NUM_PORTS-1:0][REG_W-1:0]     sel_q,
    output logic [NUM_PORTS-1:0][REG_W-1:0]     ctl_q
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(BASE_ADDR + ADDR_W'(2 * p));
        localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(BASE_ADDR + ADDR_W'(2 * p + 1));

        logic sel_hit;
        logic ctl_hit;

        // Decode a write aimed at this port's two registers.
        always_comb begin
            sel_hit = wr_en && (wr_addr == SEL_ADDR);
            ctl_hit = wr_en && (wr_addr == CTL_ADDR);
        end

        // Hold the select code; it clears to "off" on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q[p] <= SEL_OFF;
            end else if (sel_hit) begin
                sel_q[p] <= wr_data;
            end
        end

        // Hold the debug control nibble; it clears on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q[p] <= '0;
            end else if (ctl_hit) begin
                ctl_q[p] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/modem_key_mux.sv
// Module: combinational source choice for each port's keying lines.
// Assumes: port p is tied to serial channel p and bit-bang channel p;
// unknown select codes behave as "off".
module modem_key_mux
    import modem_key_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic [NUM_PORTS-1:0][REG_W-1:0] sel_q,
    input  logic [NUM_PORTS-1:0][REG_W-1:0] ctl_q,
    input  logic [NUM_PORTS-1:0]            uart_rts_n,
    input  logic [NUM_PORTS-1:0]            bb_rts_n,
    output key_t [NUM_PORTS-1:0]            key_d
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        key_t dbg_key;
        logic unused_ctl_hi;

        // Bit 3 of the control nibble carries no function.
        assign unused_ctl_hi = ctl_q[p][REG_W-1];

        // Unpack the debug control nibble into keying lines.
        always_comb begin
            dbg_key.ptt = ctl_q[p][CTL_PTT_BIT];
            dbg_key.m0  = ctl_q[p][CTL_M0_BIT];
            dbg_key.m1  = ctl_q[p][CTL_M1_BIT];
        end

        // Pick the keying pattern from the source named by the select code.
        always_comb begin
            case (sel_q[p])
                SEL_UART:  key_d[p] = key_from_rts(uart_rts_n[p]);
                SEL_BBANG: key_d[p] = key_from_rts(bb_rts_n[p]);
                SEL_DEBUG: key_d[p] = dbg_key;
                default:   key_d[p] = KEY_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/modem_key_out.sv
// Module: one register stage on every keying output.
// Assumes: the reset value is the idle pattern, so the lines are quiet from reset.
module modem_key_out
    import modem_key_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  key_t [NUM_PORTS-1:0] key_d,
    output key_t [NUM_PORTS-1:0] key_q
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Capture the selected pattern so that the lines are glitch free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[p] <= KEY_IDLE;
            end else begin
                key_q[p] <= key_d[p];
            end
        end
    end

endmodule

// File: rtl/modem_key_sel.sv
// Module: top of the modem keying selector. Register bank, source mux and
// output stage in a chain.
// Assumes: all inputs are synchronous to clk; request-to-send is active low.
module modem_key_sel
    import modem_key_pkg::*;
#(
    parameter int                NUM_PORTS = 2,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hB402_0008
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [NUM_PORTS-1:0] uart_rts_n,
    input  logic [NUM_PORTS-1:0] bb_rts_n,
    output logic [NUM_PORTS-1:0] ptt_o,
    output logic [NUM_PORTS-1:0] m0_o,
    output logic [NUM_PORTS-1:0] m1_o
);

    logic [NUM_PORTS-1:0][REG_W-1:0] sel_q;
    logic [NUM_PORTS-1:0][REG_W-1:0] ctl_q;
    key_t [NUM_PORTS-1:0]            key_d;
    key_t [NUM_PORTS-1:0]            key_q;

    modem_key_regs #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sel_q   (sel_q),
        .ctl_q   (ctl_q)
    );

    modem_key_mux #(
        .NUM_PORTS (NUM_PORTS)
    ) mux_i (
        .sel_q      (sel_q),
        .ctl_q      (ctl_q),
        .uart_rts_n (uart_rts_n),
        .bb_rts_n   (bb_rts_n),
        .key_d      (key_d)
    );

    modem_key_out #(
        .NUM_PORTS (NUM_PORTS)
    ) out_i (
        .clk   (clk),
        .rst_n (rst_n),
        .key_d (key_d),
        .key_q (key_q)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flat
        // Spread the per-port structs over the plain output vectors.
        always_comb begin
            ptt_o[p] = key_q[p].ptt;
            m0_o[p]  = key_q[p].m0;
            m1_o[p]  = key_q[p].m1;
        end
    end

endmodule

// File: rtl/modem_key_sel_chk.sv
// Module: property checker for modem_key_sel. It is attached by bind.
// Assumes: it sees the top's ports and its register bank outputs.
module modem_key_sel_chk #(
    parameter int NUM_PORTS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [NUM_PORTS-1:0][3:0]   sel_q,
    input logic [NUM_PORTS-1:0][3:0]   ctl_q,
    input logic [NUM_PORTS-1:0]        uart_rts_n,
    input logic [NUM_PORTS-1:0]        bb_rts_n,
    input logic [NUM_PORTS-1:0]        ptt_o,
    input logic [NUM_PORTS-1:0]        m0_o,
    input logic [NUM_PORTS-1:0]        m1_o
);

    // R7
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sel_q) && $stable(ctl_q)));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // R2
        uart_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[p] == 4'h1) |=> (ptt_o[p] == !$past(uart_rts_n[p]) &&
                                    m0_o[p] == !$past(uart_rts_n[p]) &&
                                    m1_o[p] == $past(uart_rts_n[p])));
        // R3
        bbang_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[p] == 4'h2) |=> (ptt_o[p] == !$past(bb_rts_n[p]) &&
                                    m0_o[p] == !$past(bb_rts_n[p]) &&
                                    m1_o[p] == $past(bb_rts_n[p])));
        // R4
        debug_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q[p] == 4'h4) |=> (ptt_o[p] == $past(ctl_q[p][0]) &&
                                    m0_o[p] == $past(ctl_q[p][1]) &&
                                    m1_o[p] == $past(ctl_q[p][2])));
        // R5
        idle_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel_q[p] == 4'h1 || sel_q[p] == 4'h2 || sel_q[p] == 4'h4)
            |=> (!ptt_o[p] && !m0_o[p] && m1_o[p]));
    end

endmodule

bind modem_key_sel modem_key_sel_chk #(
    .NUM_PORTS (NUM_PORTS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sel_q      (sel_q),
    .ctl_q      (ctl_q),
    .uart_rts_n (uart_rts_n),
    .bb_rts_n   (bb_rts_n),
    .ptt_o      (ptt_o),
    .m0_o       (m0_o),
    .m1_o       (m1_o)
);

// File: tb/modem_key_sel_tb_top.sv
// Bench: sweeps select codes, control nibbles and request-to-send levels.
// Expected outputs are computed here from the requirements.
module modem_key_sel_tb_top;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_addr = '0;
    logic [3:0]    wr_data = '0;
    logic [NP-1:0] uart_rts_n = '0;
    logic [NP-1:0] bb_rts_n = '0;
    logic [NP-1:0] ptt_o;
    logic [NP-1:0] m0_o;
    logic [NP-1:0] m1_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    modem_key_sel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .uart_rts_n (uart_rts_n),
        .bb_rts_n   (bb_rts_n),
        .ptt_o      (ptt_o),
        .m0_o       (m0_o),
        .m1_o       (m1_o)
    );

    // Expected {ptt, m0, m1} from the select code, control nibble and channel levels.
    function automatic logic [2:0] expect_key(input logic [3:0] sel, input logic [3:0] ctl,
                                              input logic u_n, input logic b_n);
        case (sel)
            4'h1:    return u_n ? 3'b001 : 3'b110;
            4'h2:    return b_n ? 3'b001 : 3'b110;
            4'h4:    return {ctl[0], ctl[1], ctl[2]};
            default: return 3'b001;
        endcase
    endfunction

    task automatic check_port(input int p, input logic [2:0] exp, input string req);
        logic [2:0] act;
        act = {ptt_o[p], m0_o[p], m1_o[p]};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port %0d: got %b expected %b", req, p, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [3:0] d, input logic en);
        @(negedge clk);
        wr_en = en;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] s0, s1, c0, c1;
        // R1: the reset state, with every request-to-send asserted
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_port(0, 3'b001, "R1");
        check_port(1, 3'b001, "R1");

        // Sweep select, control and channel levels (R2 R3 R4 R5 R9)
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                s0 = 4'(s);
                s1 = 4'((s + 5) % 16);
                c0 = 4'(c);
                c1 = ~4'(c);
                bus_write(32'hB402_0008, s0, 1'b1);
                bus_write(32'hB402_000A, s1, 1'b1);
                bus_write(32'hB402_0009, c0, 1'b1);
                bus_write(32'hB402_000B, c1, 1'b1);
                for (int r = 0; r < 16; r++) begin
                    uart_rts_n = 2'(r);
                    bb_rts_n = 2'(r >> 2);
                    @(negedge clk);
                    check_port(0, expect_key(s0, c0, uart_rts_n[0], bb_rts_n[0]),
                               "R2/R3/R4/R5 sweep");
                    check_port(1, expect_key(s1, c1, uart_rts_n[1], bb_rts_n[1]),
                               "R9 port pairing");
                end
            end
        end

        // R8: latency after an input change
        bus_write(32'hB402_0008, 4'h1, 1'b1);
        bus_write(32'hB402_000A, 4'h2, 1'b1);
        uart_rts_n = 2'b11;
        bb_rts_n = 2'b11;
        @(negedge clk);
        @(negedge clk);
        uart_rts_n = 2'b00;
        bb_rts_n = 2'b00;
        #1;
        check_port(0, 3'b001, "R8 before edge");
        check_port(1, 3'b001, "R8 before edge");
        @(negedge clk);
        check_port(0, 3'b110, "R8 after edge");
        check_port(1, 3'b110, "R8 after edge");

        // R8: latency after a register write
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 32'hB402_0008;
        wr_data = 4'h0;
        @(negedge clk);
        wr_en = 1'b0;
        check_port(0, 3'b110, "R8 write not yet visible");
        @(negedge clk);
        check_port(0, 3'b001, "R8 write visible");

        // R6: writes to addresses outside the map change nothing
        bus_write(32'hB402_0008, 4'h4, 1'b1);
        bus_write(32'hB402_0009, 4'b0110, 1'b1);
        @(negedge clk);
        check_port(0, 3'b011, "R6 setup");
        bus_write(32'hB402_0007, 4'h0, 1'b1);
        bus_write(32'hB402_000C, 4'h0, 1'b1);
        bus_write(32'hB403_0008, 4'h0, 1'b1);
        bus_write(32'h3402_0009, 4'b0001, 1'b1);
        bus_write(32'hB402_0018, 4'h0, 1'b1);
        @(negedge clk);
        check_port(0, 3'b011, "R6 other addresses");
        check_port(1, 3'b110, "R6 other addresses");

        // R7: a valid address with the strobe low changes nothing
        bus_write(32'hB402_0008, 4'h0, 1'b0);
        bus_write(32'hB402_0009, 4'b0001, 1'b0);
        bus_write(32'hB402_000A, 4'h0, 1'b0);
        @(negedge clk);
        check_port(0, 3'b011, "R7 strobe low");
        check_port(1, 3'b110, "R7 strobe low");

        // R4: bit 3 of the control nibble has no effect
        bus_write(32'hB402_0009, 4'b1110, 1'b1);
        @(negedge clk);
        check_port(0, 3'b011, "R4 bit3 ignored");

        // R1: a mid-run reset clears registers and outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_port(0, 3'b001, "R1 re-reset");
        check_port(1, 3'b001, "R1 re-reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule